// File: doc/BRIEF.md
# Multi-mode serial I/Q output formatter

This block takes parallel baseband I/Q words from one downconverter block and shifts them out on four serial pins (a, b, c, d), most significant bit first, one bit position per bit-clock enable. Words are written into a one-word holding buffer with a valid strobe. Serialisation of the buffered word begins on a frame-start pulse. The pin mode and the word length are sampled at the moment a word is loaded into the shifter.

There are three pin modes. In dual-narrowband mode, two channels each get their own I pin and Q pin. In single-wideband mode, the even and odd I and Q samples of one channel each drive their own pin. In eight-pin mode, the block works with its neighbour, which carries the Q word in the same way. The I word is striped bit by bit across all four pins, so each pin carries every fourth bit and a word takes a quarter of the bit clocks.

The controller is a two-state machine. The states are IDLE, where the pins are held low, and SHIFT, where a word is on the pins. These transitions exist:
- IDLE to SHIFT (start): a frame start arrives while the buffer is full.
- SHIFT to SHIFT (step): a bit enable arrives before the last bit position.
- SHIFT to SHIFT (chain): a frame start with a full buffer coincides with the last bit step.
- SHIFT to IDLE (finish): the last bit step arrives with no start.

Top module: `iq_serial_formatter`

## Requirements
- R1: After reset, `ser_out` is 4'b0000 and no word is pending.
- R2: With `mode_sel` = 0 (dual narrowband), pin a (`ser_out[0]`) carries `a_i`, pin b (`ser_out[1]`) carries `b_i`, pin c (`ser_out[2]`) carries `a_q` and pin d (`ser_out[3]`) carries `b_q`. Each pin carries N bits, MSB (bit N-1) first.
- R3: With `mode_sel` = 1 (single wideband), pin a carries the even I word (`a_i`), pin b the odd I word (`b_i`), pin c the even Q word (`a_q`) and pin d the odd Q word (`b_q`). Each pin carries N bits, MSB first.
- R4: With `mode_sel` = 2 (eight-pin), the word lasts ceil(N/4) bit slots. In slot s, pin p (p = 0..3 for a..d) carries bit N-1-p-4s of `a_i`. A position below bit 0 is driven 0.
- R5: `word_len` gives N, from 4 to 25. Only bits N-1..0 of each input word are sent, and higher bits have no effect on the pins.
- R6: The shifter moves on only in cycles with `bit_en` high. In other cycles, `ser_out` holds its value.
- R7: A word is loaded only at a clock edge where `bit_en`, `frame_start` and a full buffer coincide. Its first slot appears on `ser_out` after that edge. A frame start with an empty buffer leaves the pins low.
- R8: An `in_valid` pulse stores all four words in the buffer, including during shifting. A later pulse before the next load replaces the earlier one. A word written on the load edge itself is kept for the next frame.
- R9: After the last slot of a word, the next bit enable drives `ser_out` low until the next start. A frame start on a bit step that is not the word's last is ignored.
- R10: A frame start on the last bit step, with a word buffered, puts that word's first slot on the pins with no idle slot between the two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Pin mode: 0 dual, 1 wideband, 2 eight-pin |
| word_len | input | 5 | Word length N in bits (4..25) |
| bit_en | input | 1 | Bit-clock enable, one bit slot per high cycle |
| frame_start | input | 1 | Frame start pulse, effective with bit_en |
| in_valid | input | 1 | Write strobe for the four input words |
| a_i | input | 25 | Channel A I / even I / eight-pin word |
| b_i | input | 25 | Channel B I / odd I |
| a_q | input | 25 | Channel A Q / even Q |
| b_q | input | 25 | Channel B Q / odd Q |
| ser_out | output | 4 | Serial pins, bit 0 = a ... bit 3 = d |

## Verification
The bench builds the block with its default word width of 25 bits, so the full legal length range from 4 to 25 is reachable. With N = 25 in eight-pin mode, the last slot uses only pin a, which exposes the zero-fill of trailing positions. N = 4 and N = 5 give the one-slot and two-slot eight-pin cases. Random words fill all 25 input bits for every length, so bits above N that leak onto the pins would show up. Random gaps between bit enables and random chaining of words exercise the hold behaviour and the back-to-back reload.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL = 2'd0,
        MODE_WIDE = 2'd1,
        MODE_OCT  = 2'd2
    } iqf_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } iqf_state_e;

    localparam int PINS = 4;
endpackage

// File: rtl/iqf_buffer.sv
module iqf_buffer #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         take,
    input  logic [W-1:0] d_ai,
    input  logic [W-1:0] d_bi,
    input  logic [W-1:0] d_aq,
    input  logic [W-1:0] d_bq,
    output logic         full,
    output logic [W-1:0] q_ai,
    output logic [W-1:0] q_bi,
    output logic [W-1:0] q_aq,
    output logic [W-1:0] q_bq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            q_ai <= '0;
            q_bi <= '0;
            q_aq <= '0;
            q_bq <= '0;
        end else if (wr) begin
            full <= 1'b1;
            q_ai <= d_ai;
            q_bi <= d_bi;
            q_aq <= d_aq;
            q_bq <= d_bq;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/iqf_lane_map.sv
module iqf_lane_map
    import iqf_pkg::*;
#(
    parameter int W  = 25,
    parameter int LW = $clog2(W + 1)
) (
    input  logic [1:0]            mode_sel,
    input  logic [LW-1:0]         word_len,
    input  logic [W-1:0]          w_ai,
    input  logic [W-1:0]          w_bi,
    input  logic [W-1:0]          w_aq,
    input  logic [W-1:0]          w_bq,
    output logic [PINS-1:0][W-1:0] lanes,
    output logic [LW-1:0]         slots
);
    localparam int QSLOTS = (W + 3) / 4;

    logic [LW-1:0] len_c;
    logic [LW-1:0] pad;
    logic [W-1:0]  al_ai, al_bi, al_aq, al_bq;
    logic [W-1:0]  rot;

    always_comb begin
        if (word_len < LW'(4))
            len_c = LW'(4);
        else if (word_len > LW'(W))
            len_c = LW'(W);
        else
            len_c = word_len;
        pad   = LW'(W) - len_c;
        // left-align so that bit N-1 sits at position W-1, zeros below
        al_ai = w_ai << pad;
        al_bi = w_bi << pad;
        al_aq = w_aq << pad;
        al_bq = w_bq << pad;
    end

    always_comb begin
        lanes = '0;
        rot   = '0;
        if (iqf_mode_e'(mode_sel) == MODE_OCT) begin
            slots = LW'((32'(len_c) + 3) / 4);
            for (int p = 0; p < PINS; p++) begin
                rot = al_ai << p;
                for (int j = 0; j < QSLOTS; j++)
                    lanes[p][W-1-j] = rot[W-1-4*j];
            end
        end else begin
            slots    = len_c;
            lanes[0] = al_ai;
            lanes[1] = al_bi;
            lanes[2] = al_aq;
            lanes[3] = al_bq;
        end
    end
endmodule

// File: rtl/iqf_shifter.sv
module iqf_shifter
    import iqf_pkg::*;
#(
    parameter int W = 25
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   step,
    input  logic [PINS-1:0][W-1:0] lanes_in,
    output logic [PINS-1:0]        msb
);
    genvar g;
    generate
        for (g = 0; g < PINS; g++) begin : g_lane
            logic [W-1:0] sr;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sr <= '0;
                else if (load)
                    sr <= lanes_in[g];
                else if (step)
                    sr <= {sr[W-2:0], 1'b0};
            end
            assign msb[g] = sr[W-1];
        end
    endgenerate
endmodule

// File: rtl/iq_serial_formatter.sv
module iq_serial_formatter
    import iqf_pkg::*;
#(
    parameter int W  = 25,
    parameter int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [LW-1:0] word_len,
    input  logic          bit_en,
    input  logic          frame_start,
    input  logic          in_valid,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [W-1:0]  a_q,
    input  logic [W-1:0]  b_q,
    output logic [3:0]    ser_out
);
    iqf_state_e            state, state_nx;
    logic [LW-1:0]         cnt;
    logic                  buf_full;
    logic [W-1:0]          q_ai, q_bi, q_aq, q_bq;
    logic [PINS-1:0][W-1:0] lanes;
    logic [LW-1:0]         slots;
    logic [PINS-1:0]       msb;
    logic                  start, last, load, step;

    iqf_buffer #(.W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(in_valid), .take(load),
        .d_ai(a_i), .d_bi(b_i), .d_aq(a_q), .d_bq(b_q),
        .full(buf_full),
        .q_ai(q_ai), .q_bi(q_bi), .q_aq(q_aq), .q_bq(q_bq)
    );

    iqf_lane_map #(.W(W), .LW(LW)) u_map (
        .mode_sel(mode_sel), .word_len(word_len),
        .w_ai(q_ai), .w_bi(q_bi), .w_aq(q_aq), .w_bq(q_bq),
        .lanes(lanes), .slots(slots)
    );

    iqf_shifter #(.W(W)) u_sh (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .lanes_in(lanes), .msb(msb)
    );

    assign start = bit_en && frame_start && buf_full;
    assign last  = (cnt == '0);

    // next state and control strobes
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        step     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SHIFT;
                    load     = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (bit_en) begin
                    if (!last) begin
                        step = 1'b1;
                    end else if (start) begin
                        load = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (load)
                cnt <= slots - LW'(1);
            else if (step)
                cnt <= cnt - LW'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SHIFT: ser_out = msb;
            default:  ser_out = 4'b0000;
        endcase
    end
endmodule

module iqf_checker #(
    parameter int W  = 25,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          frame_start,
    input logic          in_valid,
    input logic          busy,
    input logic          buf_full,
    input logic [LW-1:0] cnt,
    input logic [3:0]    ser_out
);
    a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));

    a_r7_idle_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(bit_en && frame_start)) |=> (ser_out == 4'b0000));

    a_r8_word_captured: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> buf_full);

    a_r9_finish_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_en && cnt == '0 && !frame_start) |=> !busy);

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < LW'(W)));
endmodule

bind iq_serial_formatter iqf_checker #(.W(W), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .in_valid(in_valid), .busy(state == iqf_pkg::ST_SHIFT),
    .buf_full(buf_full), .cnt(cnt), .ser_out(ser_out)
);

// File: tb/iq_serial_formatter_test.sv
`timescale 1ns/1ps
module iq_serial_formatter_test;
    localparam int W  = 25;
    localparam int LW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_sel;
    logic [LW-1:0] word_len;
    logic          bit_en, frame_start, in_valid;
    logic [W-1:0]  a_i, b_i, a_q, b_q;
    logic [3:0]    ser_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    iq_serial_formatter #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .word_len(word_len),
        .bit_en(bit_en), .frame_start(frame_start), .in_valid(in_valid),
        .a_i(a_i), .b_i(b_i), .a_q(a_q), .b_q(b_q), .ser_out(ser_out)
    );

    function automatic int slots_of(input int m, input int len);
        return (m == 2) ? (len + 3) / 4 : len;
    endfunction

    function automatic logic [3:0] exp_pins(input int m, input int len,
        input logic [W-1:0] ai, input logic [W-1:0] bi,
        input logic [W-1:0] aq, input logic [W-1:0] bq, input int s);
        logic [3:0] r;
        int idx;
        r = 4'b0000;
        if (m == 2) begin
            for (int p = 0; p < 4; p++) begin
                idx = len - 1 - p - 4 * s;
                r[p] = (idx >= 0) ? ai[idx] : 1'b0;
            end
        end else begin
            idx = len - 1 - s;
            r = {bq[idx], aq[idx], bi[idx], ai[idx]};
        end
        return r;
    endfunction

    task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ser_out actual %b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic load_buf(input logic [W-1:0] ai, bi, aq, bq);
        in_valid = 1'b1;
        a_i = ai; b_i = bi; a_q = aq; b_q = bq;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic stream(input string rq, input int m, input int len,
        input logic [W-1:0] ai, bi, aq, bq, input int gap, input bit started,
        input bit wr_nx, input logic [W-1:0] nai, nbi, naq, nbq,
        input bit chain, input int nm, input int nl, input bit mid_fs);
        int ns;
        ns = slots_of(m, len);
        if (!started) begin
            mode_sel = 2'(m); word_len = LW'(len);
            bit_en = 1'b1; frame_start = 1'b1;
            in_valid = wr_nx; a_i = nai; b_i = nbi; a_q = naq; b_q = nbq;
            @(negedge clk);
            bit_en = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
        end else if (wr_nx) begin
            in_valid = 1'b1; a_i = nai; b_i = nbi; a_q = naq; b_q = nbq;
            @(negedge clk);
            in_valid = 1'b0;
        end
        check(rq, ser_out, exp_pins(m, len, ai, bi, aq, bq, 0));
        for (int s = 1; s < ns; s++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R6", ser_out, exp_pins(m, len, ai, bi, aq, bq, s - 1));
            end
            bit_en = 1'b1;
            frame_start = mid_fs && (s == 1);
            @(negedge clk);
            bit_en = 1'b0; frame_start = 1'b0;
            check(mid_fs ? "R9" : rq, ser_out, exp_pins(m, len, ai, bi, aq, bq, s));
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check("R6", ser_out, exp_pins(m, len, ai, bi, aq, bq, ns - 1));
        end
        bit_en = 1'b1;
        frame_start = chain;
        if (chain) begin
            mode_sel = 2'(nm); word_len = LW'(nl);
        end
        @(negedge clk);
        bit_en = 1'b0; frame_start = 1'b0;
        if (!chain) check("R9", ser_out, 4'b0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w0, w1, w2, w3, n0, n1, n2, n3;
        int m, len, nm, nl, gap;
        bit chain, prev_chain;
        int unsigned seed;
        seed = $urandom(32'd20240611);

        rst_n = 1'b0; mode_sel = 2'd0; word_len = LW'(8);
        bit_en = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
        a_i = '0; b_i = '0; a_q = '0; b_q = '0;
        repeat (3) @(negedge clk);
        check("R1", ser_out, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ser_out, 4'b0000);

        // R7: frame start with empty buffer keeps pins low
        bit_en = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; frame_start = 1'b0;
        check("R7", ser_out, 4'b0000);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        check("R7", ser_out, 4'b0000);

        // R2: dual mode, 8 bits, gap 0
        load_buf(25'h0A5, 25'h03C, 25'h0F0, 25'h081);
        check("R7", ser_out, 4'b0000);
        stream("R2", 0, 8, 25'h0A5, 25'h03C, 25'h0F0, 25'h081, 0, 0,
               0, '0, '0, '0, '0, 0, 0, 8, 0);

        // R3: wideband, full length, gap 1
        load_buf(25'h1ABCDEF, 25'h0123456, 25'h1555555, 25'h0AAAAAA);
        stream("R3", 1, 25, 25'h1ABCDEF, 25'h0123456, 25'h1555555, 25'h0AAAAAA, 1, 0,
               0, '0, '0, '0, '0, 0, 0, 8, 0);

        // R4: eight-pin, 25 bits (last slot only pin a), then 5 bits and 4 bits
        load_buf(25'h1F0F0F1, '0, '0, '0);
        stream("R4", 2, 25, 25'h1F0F0F1, '0, '0, '0, 0, 0, 0, '0, '0, '0, '0, 0, 0, 8, 0);
        load_buf(25'h1FFFF13, '0, '0, '0);
        stream("R4", 2, 5, 25'h1FFFF13, '0, '0, '0, 1, 0, 0, '0, '0, '0, '0, 0, 0, 8, 0);
        load_buf(25'h0000009, '0, '0, '0);
        stream("R4", 2, 4, 25'h0000009, '0, '0, '0, 0, 0, 0, '0, '0, '0, '0, 0, 0, 8, 0);

        // R5: length 4 with garbage above bit 3
        load_buf(25'h1FFFFF5, 25'h1AAAAA3, 25'h0F0F0FC, 25'h1234560);
        stream("R5", 0, 4, 25'h1FFFFF5, 25'h1AAAAA3, 25'h0F0F0FC, 25'h1234560, 2, 0,
               0, '0, '0, '0, '0, 0, 0, 8, 0);

        // R8: second write replaces the first
        load_buf(25'h0000011, 25'h0000022, 25'h0000033, 25'h0000044);
        load_buf(25'h00000C3, 25'h000005A, 25'h00000E7, 25'h0000018);
        stream("R8", 0, 8, 25'h00000C3, 25'h000005A, 25'h00000E7, 25'h0000018, 0, 0,
               0, '0, '0, '0, '0, 0, 0, 8, 0);

        // R9: mid-word frame start with a full buffer is ignored; R8 word held
        load_buf(25'h0000096, 25'h0000069, 25'h00000F1, 25'h000001F);
        stream("R9", 0, 8, 25'h0000096, 25'h0000069, 25'h00000F1, 25'h000001F, 1, 0,
               1, 25'h00000B2, 25'h000002B, 25'h00000D4, 25'h000004D, 0, 0, 8, 1);
        @(negedge clk);
        check("R9", ser_out, 4'b0000);
        stream("R8", 0, 8, 25'h00000B2, 25'h000002B, 25'h00000D4, 25'h000004D, 0, 0,
               1, 25'h1C3A5F0, '0, '0, '0, 1, 2, 25, 0);
        // R10: chained word starts on the next slot
        stream("R10", 2, 25, 25'h1C3A5F0, '0, '0, '0, 0, 1,
               0, '0, '0, '0, '0, 0, 0, 8, 0);

        // random mix
        m = 0; len = 12;
        w0 = W'($urandom); w1 = W'($urandom); w2 = W'($urandom); w3 = W'($urandom);
        load_buf(w0, w1, w2, w3);
        prev_chain = 1'b0;
        for (int it = 0; it < 60; it++) begin
            n0 = W'($urandom); n1 = W'($urandom); n2 = W'($urandom); n3 = W'($urandom);
            nm = int'($urandom % 3);
            nl = 4 + int'($urandom % 22);
            gap = int'($urandom % 3);
            chain = ($urandom % 2) == 1;
            stream((m == 0) ? "R2" : (m == 1) ? "R3" : "R4", m, len, w0, w1, w2, w3, gap,
                   prev_chain, 1, n0, n1, n2, n3, chain, nm, nl, 0);
            w0 = n0; w1 = n1; w2 = n2; w3 = n3;
            m = nm; len = nl; prev_chain = chain;
        end
        if (prev_chain) begin
            stream("R10", m, len, w0, w1, w2, w3, 0, 1, 0, '0, '0, '0, '0, 0, 0, 8, 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule